// File: doc/BRIEF.md
# ROM/RAM Combo Memory Controller

This block is a synchronous, host-side controller for an external asynchronous memory device. The device has two regions: a 512K x 8 read-only region and a 32K x 8 static RAM region. A host issues single-beat requests over a valid/ready port. Each request is one of three kinds: a ROM read, a RAM read or a RAM write. For each request the controller drives the 19-bit address bus, an active-low ROM select, and one active-low pin that is shared between ROM output enable and RAM select. It also drives an active-low write strobe and the enable for its own data-bus drivers. Read data comes back with a one-cycle response pulse.

Every phase of a device cycle is a whole number of clock cycles. Each phase length comes from a minimum time in nanoseconds and the clock period parameter `CLK_NS`, rounded up. At the default 5 ns clock the phase lengths are:

| Quantity | Time | Cycles |
|---|---|---|
| `N_ACC`, access | 500 ns | 100 |
| `N_FLT`, float recovery | 40 ns | 8 |
| `N_TURN`, write turnaround | 80 ns | 16 |
| `N_DATA`, write data phase | 410 ns | 82 |

`N_DATA` is the largest of these four values:
- the data setup time, 200 ns (40 cycles);
- the write overlap minimum, 400 ns, less the turnaround (64 cycles);
- the select-to-end time, 365 ns, less the turnaround (57 cycles);
- the cycle minimum, 500 ns, less the turnaround and the two single-cycle steps (82 cycles).

The state machine has these states:
- `S_IDLE`
- `S_ROM_RD`
- `S_RAM_RD`
- `S_WR_WE`
- `S_WR_TURN`
- `S_WR_DATA`
- `S_WR_END`
- `S_FLOAT`

It makes these transitions:
- From `S_IDLE`, an accepted request goes to one of four states:
  - a ROM read goes to `S_ROM_RD`;
  - a RAM read goes to `S_RAM_RD`;
  - a RAM write goes to `S_WR_WE`;
  - a write aimed at the ROM region goes straight to `S_FLOAT`.
- `S_ROM_RD` and `S_RAM_RD` go to `S_FLOAT` when their phase ends.
- A write steps `S_WR_WE` → `S_WR_TURN` → `S_WR_DATA` → `S_WR_END` → `S_FLOAT`.
- `S_FLOAT` goes to `S_IDLE`.

Each state is left when its phase counter, which is loaded on entry, reaches zero.

Top module: `rrc_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, the pins are in the standby state. ROM select, the shared pin and the write strobe are all 1, and the data drivers are off (`mem_d_drive`=0). At the same time `req_ready`=1 and `rsp_valid`=0.
- R2: A ROM read (`req_ram`=0, `req_write`=0) holds ROM select and the shared pin both at 0 for exactly `N_ACC` cycles, with all 19 request address bits on `mem_addr`. The byte on `mem_d_in` in the last of those cycles is returned on `rsp_rdata`.
- R3: A RAM read (`req_ram`=1, `req_write`=0) holds ROM select at 1, the shared pin at 0 and the write strobe at 1 for exactly `N_ACC` cycles. It returns the byte sampled in the last of those cycles. During any RAM access, `mem_addr[14:0]` equals the request address and `mem_addr[18:15]` is 0.
- R4: A RAM write (`req_ram`=1, `req_write`=1) proceeds in this order:
  - The write strobe falls one cycle before the shared pin, so exactly one cycle has the strobe at 0 with the shared pin at 1.
  - The data drivers turn on `N_TURN` cycles after the shared pin falls. They drive `req_wdata` for `N_DATA` cycles.
  - The strobe then rises, and the drivers turn off on the same edge.
  - The shared pin rises one cycle later.
  
  The overlap of both pins at 0 therefore lasts `N_TURN`+`N_DATA` cycles (at least 400 ns). Data is stable for at least 200 ns before the end of the write.
- R5: Every accepted request ends with `N_FLT` cycles in which all pins are in standby before the response pulse. This includes a ROM-region write.
- R6: `req_ready` is 1 only in `S_IDLE`. `rsp_valid` is a single-cycle pulse. The pulse comes `N_ACC`+`N_FLT` cycles after the accepting edge for reads, `2`+`N_TURN`+`N_DATA`+`N_FLT` cycles after it for RAM writes, and `N_FLT` cycles after it for ROM-region writes.
- R7: A write request aimed at the ROM region (`req_ram`=0, `req_write`=1) causes no pin activity, and it still receives a response.
- R8: The data drivers are on only while the write strobe and the shared pin are both 0 and ROM select is 1. The controller and the device never drive the data bus in the same cycle.
- R9: `mem_addr` stays unchanged from the first busy cycle until the controller is idle again.
- R10: `rsp_rdata` keeps the last read result. RAM writes and ROM-region writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_ram | input | 1 | 1 selects the RAM region, 0 the ROM region |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read data |
| mem_addr | output | 19 | Device address bus |
| mem_rom_sel_n | output | 1 | Device ROM select, active low |
| mem_share_n | output | 1 | Shared output enable / RAM select, active low |
| mem_wr_n | output | 1 | Device write strobe, active low |
| mem_d_out | output | 8 | Data driven toward the device |
| mem_d_drive | output | 1 | Enable for the controller's data drivers |
| mem_d_in | input | 8 | Data bus as seen by the controller |

## Verification
Pins change on the edge that accepts a request. The response pulse then appears 108 cycles after that edge for reads and RAM writes at the default timing, and 8 cycles after it for a ROM-region write. The bench drives its inputs on falling edges and counts rising edges from the accepting edge up to the first falling-edge sample that shows `rsp_valid`. It compares that count with the latency required by R6. The bench counts pin phases once per cycle at falling edges and reads the counters only on the rising edge after the response. A device model also samples on falling edges. Its read data is valid only once a full 500 ns has passed since the address and selects settled, so a capture made one cycle early returns a marker byte instead of the data.

// File: rtl/rrc_pkg.sv
`timescale 1ns/1ps
package rrc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROM_RD,
        S_RAM_RD,
        S_WR_WE,
        S_WR_TURN,
        S_WR_DATA,
        S_WR_END,
        S_FLOAT
    } rrc_state_e;

    // Minimum time in ns converted to whole clock cycles, at least one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rrc_phase_timer.sv
`timescale 1ns/1ps
module rrc_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/rrc_req_latch.sv
`timescale 1ns/1ps
module rrc_req_latch #(
    parameter int ADDR_W = 19,
    parameter int RAM_AW = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              ram,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] wdata_out
);
    localparam int HI_W = ADDR_W - RAM_AW;

    logic [ADDR_W-1:0] addr_next;

    // RAM accesses pin the unused upper address bits to a constant 0.
    generate
        if (HI_W > 0) begin : g_hi
            assign addr_next = ram ? {{HI_W{1'b0}}, addr_in[RAM_AW-1:0]} : addr_in;
        end else begin : g_flat
            assign addr_next = addr_in;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_out  <= '0;
            wdata_out <= '0;
        end else if (take) begin
            addr_out  <= addr_next;
            wdata_out <= wdata_in;
        end
    end
endmodule

// File: rtl/rrc_rd_capture.sv
`timescale 1ns/1ps
module rrc_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (sample) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/rrc_ctrl.sv
`timescale 1ns/1ps
module rrc_ctrl
    import rrc_pkg::*;
#(
    parameter int CLK_NS     = 5,
    parameter int ADDR_W     = 19,
    parameter int RAM_AW     = 15,
    parameter int DATA_W     = 8,
    parameter int T_ACC_NS   = 500,
    parameter int T_FLOAT_NS = 40,
    parameter int T_TURN_NS  = 80,
    parameter int T_WP_NS    = 400,
    parameter int T_CW_NS    = 365,
    parameter int T_DW_NS    = 200,
    parameter int T_WC_NS    = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_ram,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rom_sel_n,
    output logic              mem_share_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_d_out,
    output logic              mem_d_drive,
    input  logic [DATA_W-1:0] mem_d_in
);
    // Phase lengths in cycles.
    localparam int N_ACC  = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int N_FLT  = ns_to_cyc(T_FLOAT_NS, CLK_NS);
    localparam int N_TURN = ns_to_cyc(T_TURN_NS, CLK_NS);
    localparam int N_OVL  = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int N_CW   = ns_to_cyc(T_CW_NS, CLK_NS);
    localparam int N_DW   = ns_to_cyc(T_DW_NS, CLK_NS);
    localparam int N_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int N_DATA = max2(max2(N_DW, N_OVL - N_TURN),
                                 max2(N_CW - N_TURN, N_WC - N_TURN - 2));
    localparam int N_MAX  = max2(max2(N_ACC, N_FLT), max2(N_TURN, N_DATA));
    localparam int CNT_W  = $clog2(N_MAX + 1);

    localparam logic [CNT_W-1:0] L_ACC  = CNT_W'(N_ACC - 1);
    localparam logic [CNT_W-1:0] L_FLT  = CNT_W'(N_FLT - 1);
    localparam logic [CNT_W-1:0] L_TURN = CNT_W'(N_TURN - 1);
    localparam logic [CNT_W-1:0] L_DATA = CNT_W'(N_DATA - 1);

    rrc_state_e       state_q, state_d;
    logic             phase_done;
    logic             phase_load;
    logic [CNT_W-1:0] phase_len;
    logic             accept;
    logic             rd_sample;
    logic             rsp_q;

    assign accept = (state_q == S_IDLE) && req_valid;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_ram) begin
                        state_d = req_write ? S_WR_WE : S_RAM_RD;
                    end else begin
                        state_d = req_write ? S_FLOAT : S_ROM_RD;
                    end
                end
            end
            S_ROM_RD:  if (phase_done) state_d = S_FLOAT;
            S_RAM_RD:  if (phase_done) state_d = S_FLOAT;
            S_WR_WE:   if (phase_done) state_d = S_WR_TURN;
            S_WR_TURN: if (phase_done) state_d = S_WR_DATA;
            S_WR_DATA: if (phase_done) state_d = S_WR_END;
            S_WR_END:  if (phase_done) state_d = S_FLOAT;
            S_FLOAT:   if (phase_done) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Phase length loaded on entry to the next state.
    always_comb begin
        phase_len = '0;
        unique case (state_d)
            S_ROM_RD, S_RAM_RD:  phase_len = L_ACC;
            S_WR_TURN:           phase_len = L_TURN;
            S_WR_DATA:           phase_len = L_DATA;
            S_FLOAT:             phase_len = L_FLT;
            default:             phase_len = '0;
        endcase
    end

    assign phase_load = (state_d != state_q);
    assign rd_sample  = ((state_q == S_ROM_RD) || (state_q == S_RAM_RD)) && phase_done;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= 1'b0;
        end else begin
            rsp_q <= (state_q == S_FLOAT) && phase_done;
        end
    end

    // Pin decode from the state.
    always_comb begin
        mem_rom_sel_n = 1'b1;
        mem_share_n   = 1'b1;
        mem_wr_n      = 1'b1;
        mem_d_drive   = 1'b0;
        req_ready     = 1'b0;
        unique case (state_q)
            S_IDLE:   req_ready = 1'b1;
            S_ROM_RD: begin
                mem_rom_sel_n = 1'b0;
                mem_share_n   = 1'b0;
            end
            S_RAM_RD: mem_share_n = 1'b0;
            S_WR_WE:  mem_wr_n = 1'b0;
            S_WR_TURN: begin
                mem_wr_n    = 1'b0;
                mem_share_n = 1'b0;
            end
            S_WR_DATA: begin
                mem_wr_n    = 1'b0;
                mem_share_n = 1'b0;
                mem_d_drive = 1'b1;
            end
            S_WR_END: mem_share_n = 1'b0;
            S_FLOAT:  ;
            default:  ;
        endcase
    end

    assign rsp_valid = rsp_q;

    rrc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_len),
        .done     (phase_done)
    );

    rrc_req_latch #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .ram       (req_ram),
        .addr_in   (req_addr),
        .wdata_in  (req_wdata),
        .addr_out  (mem_addr),
        .wdata_out (mem_d_out)
    );

    rrc_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (rd_sample),
        .din    (mem_d_in),
        .dout   (rsp_rdata)
    );
endmodule

// File: rtl/rrc_ctrl_checker.sv
`timescale 1ns/1ps
module rrc_ctrl_checker #(
    parameter int ADDR_W  = 19,
    parameter int RAM_AW  = 15,
    parameter int MIN_OVL = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rom_sel_n,
    input logic              mem_share_n,
    input logic              mem_wr_n,
    input logic              mem_d_drive
);
    logic [15:0] ovl_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovl_cnt <= '0;
        end else if (!mem_wr_n && !mem_share_n && mem_rom_sel_n) begin
            ovl_cnt <= ovl_cnt + 1'b1;
        end else begin
            ovl_cnt <= '0;
        end
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_rom_sel_n && mem_share_n && mem_wr_n && !mem_d_drive));

    assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_share_n && mem_rom_sel_n) |-> (mem_addr[ADDR_W-1:RAM_AW] == '0));

    assert_strobe_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_share_n) && mem_rom_sel_n && !mem_wr_n) |-> $past(!mem_wr_n));

    assert_overlap_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_wr_n) && !mem_share_n) |-> (ovl_cnt >= 16'(MIN_OVL)));

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_d_drive |-> (!mem_wr_n && !mem_share_n && mem_rom_sel_n));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));
endmodule

bind rrc_ctrl rrc_ctrl_checker #(
    .ADDR_W  (ADDR_W),
    .RAM_AW  (RAM_AW),
    .MIN_OVL (N_OVL)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_addr      (mem_addr),
    .mem_rom_sel_n (mem_rom_sel_n),
    .mem_share_n   (mem_share_n),
    .mem_wr_n      (mem_wr_n),
    .mem_d_drive   (mem_d_drive)
);

// File: tb/rrc_ctrl_test.sv
`timescale 1ns/1ps
module rrc_ctrl_test;
    // Expected phase lengths at a 5 ns clock.
    localparam int E_ACC  = 100;
    localparam int E_FLT  = 8;
    localparam int E_TURN = 16;
    localparam int E_DATA = 82;
    localparam int LAT_RD = E_ACC + E_FLT;
    localparam int LAT_WR = 2 + E_TURN + E_DATA + E_FLT;
    localparam int NVEC   = 12;

    // {ram, write, addr[18:0], wdata[7:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 19'h00000, 8'h00},
        {1'b0, 1'b0, 19'h7FFFF, 8'h00},
        {1'b1, 1'b1, 19'h00123, 8'hA5},
        {1'b1, 1'b0, 19'h00123, 8'h00},
        {1'b1, 1'b1, 19'h07FFF, 8'h3C},
        {1'b1, 1'b0, 19'h07FFF, 8'h00},
        {1'b1, 1'b0, 19'h78123, 8'h00},
        {1'b1, 1'b1, 19'h58001, 8'h77},
        {1'b1, 1'b0, 19'h00001, 8'h00},
        {1'b0, 1'b0, 19'h2A5A5, 8'h00},
        {1'b0, 1'b1, 19'h01234, 8'hFF},
        {1'b1, 1'b0, 19'h05555, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_ram = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_rom_sel_n;
    logic        mem_share_n;
    logic        mem_wr_n;
    logic [7:0]  mem_d_out;
    logic        mem_d_drive;
    logic [7:0]  mem_d_in = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rrc_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_ram       (req_ram),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .mem_addr      (mem_addr),
        .mem_rom_sel_n (mem_rom_sel_n),
        .mem_share_n   (mem_share_n),
        .mem_wr_n      (mem_wr_n),
        .mem_d_out     (mem_d_out),
        .mem_d_drive   (mem_d_drive),
        .mem_d_in      (mem_d_in)
    );

    function automatic logic [7:0] rom_fn(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- device responder (samples at falling edges) -------
    logic [7:0] dev_ram [int];
    int  age = 0;
    logic [21:0] prev_key = '0;
    bit  prev_wr = 1'b0;
    int  ovl_run = 0;
    int  dstab_run = 0;
    logic [7:0] last_d = '0;
    int  wr_short = 0;
    int  dw_short = 0;
    int  contention = 0;

    always @(negedge clk) begin
        bit rd_rom, rd_ram, wr_now;
        logic [21:0] key;
        int k;
        rd_rom = !mem_rom_sel_n && !mem_share_n;
        rd_ram = mem_rom_sel_n && !mem_share_n && mem_wr_n;
        wr_now = mem_rom_sel_n && !mem_share_n && !mem_wr_n;
        key = {mem_rom_sel_n, mem_share_n, mem_wr_n, mem_addr};
        k = int'(mem_addr[14:0]);
        if (prev_wr && !wr_now) begin
            if (ovl_run * 5 < 400) wr_short++;
            if (dstab_run * 5 < 200) dw_short++;
            dev_ram[k] = last_d;
        end
        if (wr_now) begin
            ovl_run = prev_wr ? ovl_run + 1 : 1;
            if (mem_d_drive) begin
                dstab_run = (dstab_run > 0 && mem_d_out == last_d) ? dstab_run + 1 : 1;
                last_d = mem_d_out;
            end else begin
                dstab_run = 0;
            end
        end
        prev_wr = wr_now;
        if (rd_rom || rd_ram) begin
            age = (key == prev_key) ? age + 1 : 1;
            if (mem_d_drive) contention++;
        end else begin
            age = 0;
        end
        prev_key = key;
        if ((rd_rom || rd_ram) && age * 5 >= 500) begin
            if (rd_rom) mem_d_in <= rom_fn(mem_addr);
            else        mem_d_in <= dev_ram.exists(k) ? dev_ram[k] : 8'h00;
        end else if (rd_rom || rd_ram) begin
            mem_d_in <= 8'hEE;
        end else begin
            mem_d_in <= 8'h00;
        end
    end

    // ---------------- pin phase monitor ---------------------------------
    int m_rom = 0, m_ramrd = 0, m_ovl = 0, m_drv = 0, m_first = 0;
    int m_idle = 0, m_upper = 0, m_amis = 0;
    logic [18:0] exp_pin_addr = '0;

    always @(negedge clk) begin
        if (!mem_rom_sel_n && !mem_share_n) m_rom++;
        if (mem_rom_sel_n && !mem_share_n && mem_wr_n) m_ramrd++;
        if (mem_rom_sel_n && !mem_share_n && !mem_wr_n) m_ovl++;
        if (mem_d_drive) m_drv++;
        if (mem_rom_sel_n && mem_share_n && !mem_wr_n) m_first++;
        if (mem_rom_sel_n && mem_share_n && mem_wr_n && !mem_d_drive) m_idle++;
        if (mem_rom_sel_n && !mem_share_n && mem_addr[18:15] != 4'h0) m_upper++;
        if ((!mem_rom_sel_n || !mem_share_n) && mem_addr != exp_pin_addr) m_amis++;
    end

    logic [7:0] shadow [int];
    logic [7:0] last_rd = 8'h00;

    task automatic do_req(input logic ram, input logic wr,
                          input logic [18:0] a, input logic [7:0] d);
        int lat;
        int exp_lat;
        logic [7:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1;
        req_ram   = ram;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        exp_pin_addr = ram ? {4'h0, a[14:0]} : a;
        @(posedge clk);
        m_rom = 0; m_ramrd = 0; m_ovl = 0; m_drv = 0; m_first = 0;
        m_idle = 0; m_upper = 0; m_amis = 0;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (lat < 1000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 3) chk(req_ready == 1'b0, "R6", "ready while busy", req_ready, 0);
            if (rsp_valid) break;
        end
        exp_lat = (ram && wr) ? LAT_WR : ((!ram && wr) ? E_FLT : LAT_RD);
        chk(lat == exp_lat, "R6", "response latency", lat, exp_lat);
        chk(req_ready == 1'b1, "R1", "ready with response", req_ready, 1);
        @(posedge clk);
        // Idle count includes the response cycle itself.
        chk(m_idle == E_FLT + 1, "R5", "float recovery cycles", m_idle, E_FLT + 1);
        chk(m_amis == 0, "R9", "address off during access", m_amis, 0);
        if (!ram && !wr) begin
            exp_rd = rom_fn(a);
            chk(m_rom == E_ACC, "R2", "rom access cycles", m_rom, E_ACC);
            chk(rsp_rdata == exp_rd, "R2", "rom read data", rsp_rdata, exp_rd);
            last_rd = exp_rd;
        end else if (ram && !wr) begin
            exp_rd = shadow.exists(int'(a[14:0])) ? shadow[int'(a[14:0])] : 8'h00;
            chk(m_ramrd == E_ACC, "R3", "ram access cycles", m_ramrd, E_ACC);
            chk(m_upper == 0, "R3", "upper address bits", m_upper, 0);
            chk(rsp_rdata == exp_rd, "R3", "ram read data", rsp_rdata, exp_rd);
            last_rd = exp_rd;
        end else if (ram && wr) begin
            chk(m_first == 1, "R4", "strobe-before-select cycles", m_first, 1);
            chk(m_ovl == E_TURN + E_DATA, "R4", "overlap cycles", m_ovl, E_TURN + E_DATA);
            chk(m_drv == E_DATA, "R4", "driver cycles", m_drv, E_DATA);
            chk(m_ramrd == 1, "R4", "select held after strobe", m_ramrd, 1);
            chk(m_upper == 0, "R3", "upper address bits on write", m_upper, 0);
            chk(rsp_rdata == last_rd, "R10", "rdata after ram write", rsp_rdata, last_rd);
            shadow[int'(a[14:0])] = d;
        end else begin
            chk(m_rom + m_ramrd + m_ovl + m_drv + m_first == 0, "R7",
                "pin activity on rom write", m_rom + m_ramrd + m_ovl + m_first, 0);
            chk(rsp_rdata == last_rd, "R10", "rdata after rom write", rsp_rdata, last_rd);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R6", "response pulse width", rsp_valid, 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state.
        repeat (3) @(negedge clk);
        chk(mem_rom_sel_n && mem_share_n && mem_wr_n && !mem_d_drive, "R1",
            "standby pins in reset", {mem_rom_sel_n, mem_share_n, mem_wr_n, mem_d_drive}, 4'b1110);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
        chk(mem_rom_sel_n && mem_share_n && mem_wr_n && !mem_d_drive, "R1",
            "standby pins after reset", {mem_rom_sel_n, mem_share_n, mem_wr_n, mem_d_drive}, 4'b1110);

        // Vector table.
        for (int i = 0; i < NVEC; i++) begin
            do_req(VEC[i][28], VEC[i][27], VEC[i][26:8], VEC[i][7:0]);
        end

        // Corner: ROM write directly after a RAM write keeps rdata (R10, R7).
        do_req(1'b1, 1'b1, 19'h00010, 8'hC3);
        do_req(1'b0, 1'b1, 19'h00010, 8'h11);
        // Corner: read back the byte just written, then a ROM read of the same address.
        do_req(1'b1, 1'b0, 19'h00010, 8'h00);
        do_req(1'b0, 1'b0, 19'h00010, 8'h00);

        // Device-side timing and contention (R4, R8).
        chk(wr_short == 0, "R4", "device saw short write pulse", wr_short, 0);
        chk(dw_short == 0, "R4", "device saw short data setup", dw_short, 0);
        chk(contention == 0, "R8", "bus contention cycles", contention, 0);
        chk(req_ready && mem_rom_sel_n && mem_share_n && mem_wr_n, "R1",
            "standby at end", req_ready, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule